// File: doc/BRIEF.md
# Edge-latched interrupt status controller

This block gathers a set of interrupt source lines into a sticky status register and drives a single interrupt request. Each source passes through a two-flop synchroniser and an edge detector; when its enable bit is set, a rising edge on the source latches that source's status bit to one. The request line rises when the status value as a whole leaves zero, and it stays high until every status bit is zero again.

No separate clear register exists. Software clears a status bit by writing zero to the matching enable bit, and it re-arms the source by writing one again. A small register port gives the host access: address 0 holds the read/write enable register and address 1 holds the read-only status register. Reads are combinational and have no side effects.

Top module: `edge_irq_collector`

## Requirements
- R1: After reset the enable register, the status register and the request output are all zero.
- R2: A write to address 0 stores the write data in the enable register, and a read of address 0 returns the last value written. A write to address 1 changes nothing.
- R3: A rising edge on an enabled source sets its status bit. A source that rises while the clock samples it reads as set in status after the third rising clock edge, and not after the second; the extra edges are the two-flop synchroniser.
- R4: An edge on a disabled source is ignored, and a status bit whose enable is 0 reads 0. A source already high when it is enabled does not set its bit until it falls and rises again.
- R5: A set status bit stays set when its source falls or rises again. It is cleared only by writing 0 to its enable bit, and it reads 0 from the clock edge of that write onward.
- R6: The request output rises one clock after the status value changes from zero to non-zero.
- R7: The request output stays high while any status bit is set, including while some bits are cleared, and falls one clock after the whole status value is zero.
- R8: An edge whose detection falls in the same cycle as a write that clears its enable bit is dropped. Re-enabling the source later does not bring the edge back.
- R9: Reading the status register, at either address and any number of times, leaves status and request unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | 6 | Asynchronous interrupt source lines, bit i is source i |
| bus_addr | input | 1 | Register address: 0 selects enable, 1 selects status |
| bus_wr | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | 6 | Write data |
| bus_rdata | output | 6 | Read data for the register at bus_addr |
| irq_req | output | 1 | Interrupt request |

## Verification
The bench counts clock edges from a source change, so a design with one synchroniser stage too many or too few shows the status bit a cycle early or late. It times a source edge to meet the enable-clearing write in the same cycle. A design that qualifies the edge with the old enable keeps a bit that should be dropped, and that bit then shows up as a set status bit with the request still high. It clears sources one at a time while another stays set, so a design that drops the request on any clear, or that pulses the request instead of holding it, is caught. It enables a source that is already high, which catches a design that latches on level instead of on edge. It also writes to the status address, which catches a design that lets that write through to status.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned NUM_SRC = 6;
  localparam int unsigned ADDR_W  = 1;
  localparam logic [ADDR_W-1:0] ADDR_ENABLE = 1'b0;
  localparam logic [ADDR_W-1:0] ADDR_STATUS = 1'b1;
endpackage

// File: rtl/irqc_sync_edge.sv
module irqc_sync_edge #(
  parameter int unsigned WIDTH  = 6,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] rise_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic [WIDTH-1:0] chain_q [STAGES];
  logic [WIDTH-1:0] prev_q;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[s] <= '0;
          else        chain_q[s] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[s] <= '0;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= chain_q[LAST];
  end

  assign rise_o = chain_q[LAST] & ~prev_q;

  // R3: a detected edge lasts exactly one cycle per rising transition
  assert_edge_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_o != '0) |=> ((rise_o & $past(rise_o)) == '0));
endmodule

// File: rtl/irqc_status_regs.sv
module irqc_status_regs #(
  parameter int unsigned WIDTH = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] rise_i,
  input  logic             en_wr_i,
  input  logic [WIDTH-1:0] en_wdata_i,
  output logic [WIDTH-1:0] enable_o,
  output logic [WIDTH-1:0] status_o
);
  logic [WIDTH-1:0] enable_q, enable_d;
  logic [WIDTH-1:0] status_q, status_d;

  always_comb begin
    enable_d = en_wr_i ? en_wdata_i : enable_q;
    // edges count only on sources enabled now; a clear in this cycle wins
    status_d = (status_q | (rise_i & enable_q)) & enable_d;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable_q <= '0;
      status_q <= '0;
    end else begin
      enable_q <= enable_d;
      status_q <= status_d;
    end
  end

  assign enable_o = enable_q;
  assign status_o = status_q;

  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_chk
      // R5: a set bit survives unless its enable is written to zero
      assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q[i] && !(en_wr_i && !en_wdata_i[i])) |=> status_q[i]);
      // R3: an enabled edge with no clearing write sets the bit
      assert_edge_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_i[i] && enable_q[i] && !(en_wr_i && !en_wdata_i[i])) |=> status_q[i]);
      // R4: a bit never rises while its source was disabled
      assert_disabled_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable_q[i] && !status_q[i]) |=> !status_q[i]);
      // R8: a clearing write drops the bit even with a coincident edge
      assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (en_wr_i && !en_wdata_i[i]) |=> !status_q[i]);
    end
  endgenerate
endmodule

// File: rtl/irqc_request.sv
module irqc_request #(
  parameter int unsigned WIDTH = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] status_i,
  output logic             irq_o
);
  logic was_zero_q;
  logic irq_q;
  logic now_zero;

  assign now_zero = (status_i == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      was_zero_q <= 1'b1;
      irq_q      <= 1'b0;
    end else begin
      was_zero_q <= now_zero;
      if (now_zero)
        irq_q <= 1'b0;
      else if (!irq_q)
        irq_q <= 1'b1;
    end
  end

  assign irq_o = irq_q;

  // R6: the request only rises after the status left zero
  assert_rise_from_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> ($past(status_i) != '0));
  // R7: while status is non-zero the request is held high next cycle
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!now_zero) |=> irq_q);
  // R7: an all-zero status drops the request next cycle
  assert_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    now_zero |=> !irq_q);
  // R6: a zero-to-nonzero step is always followed by a high request
  assert_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (was_zero_q && !now_zero) |=> irq_q);
endmodule

// File: rtl/edge_irq_collector.sv
module edge_irq_collector
  import irqc_pkg::*;
#(
  parameter int unsigned SRC_W     = NUM_SRC,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SRC_W-1:0]  src_in,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [SRC_W-1:0]  bus_wdata,
  output logic [SRC_W-1:0]  bus_rdata,
  output logic              irq_req
);
  logic [SRC_W-1:0] rise;
  logic [SRC_W-1:0] enable;
  logic [SRC_W-1:0] status;
  logic             en_wr;

  assign en_wr = bus_wr && (bus_addr == ADDR_ENABLE);

  irqc_sync_edge #(.WIDTH(SRC_W), .STAGES(SYNC_DEPTH)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (src_in),
    .rise_o  (rise)
  );

  irqc_status_regs #(.WIDTH(SRC_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .rise_i     (rise),
    .en_wr_i    (en_wr),
    .en_wdata_i (bus_wdata),
    .enable_o   (enable),
    .status_o   (status)
  );

  irqc_request #(.WIDTH(SRC_W)) u_req (
    .clk      (clk),
    .rst_n    (rst_n),
    .status_i (status),
    .irq_o    (irq_req)
  );

  always_comb begin
    bus_rdata = (bus_addr == ADDR_STATUS) ? status : enable;
  end

  // R9: with no write, status cannot drop
  assert_read_no_effect_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> (($past(status) & ~status) == '0));
  // R2: a write to the status address leaves the enable register alone
  assert_status_wr_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_STATUS) |=> $stable(enable));
endmodule

// File: tb/edge_irq_collector_tb_top.sv
module edge_irq_collector_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] src_in = '0;
  logic       bus_addr = 1'b0;
  logic       bus_wr = 1'b0;
  logic [5:0] bus_wdata = '0;
  logic [5:0] bus_rdata;
  logic       irq_req;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  edge_irq_collector dut_i (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_req(irq_req)
  );

  task automatic check(input string req, input string what,
                       input logic [5:0] act, input logic [5:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [5:0] d);
    bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 1'b0;
  endtask

  function automatic logic [5:0] rd(input logic a);
    return 6'h0;
  endfunction

  task automatic read(input logic a, output logic [5:0] v);
    bus_addr = a; #1 v = bus_rdata;
  endtask

  task automatic do_reset();
    src_in = '0; bus_wr = 1'b0; rst_n = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
  endtask

  task automatic t_reset();
    logic [5:0] v;
    do_reset();
    read(1'b0, v); check("R1", "enable after reset", v, 6'h00);
    read(1'b1, v); check("R1", "status after reset", v, 6'h00);
    check("R1", "irq after reset", {5'b0, irq_req}, 6'h00);
  endtask

  task automatic t_enable_rw();
    logic [5:0] v;
    do_reset();
    wr(1'b0, 6'h2d);
    read(1'b0, v); check("R2", "enable readback", v, 6'h2d);
    wr(1'b1, 6'h3f);
    read(1'b0, v); check("R2", "enable after status write", v, 6'h2d);
    read(1'b1, v); check("R2", "status after status write", v, 6'h00);
    check("R2", "irq after status write", {5'b0, irq_req}, 6'h00);
  endtask

  task automatic t_latency();
    logic [5:0] v;
    do_reset();
    wr(1'b0, 6'h3f);
    src_in = 6'h04;
    cyc(2);
    read(1'b1, v); check("R3", "status after two edges", v, 6'h00);
    cyc(1);
    read(1'b1, v); check("R3", "status after three edges", v, 6'h04);
    check("R6", "irq same cycle as status", {5'b0, irq_req}, 6'h00);
    cyc(1);
    check("R6", "irq one cycle after status", {5'b0, irq_req}, 6'h01);
  endtask

  task automatic t_disabled();
    logic [5:0] v;
    do_reset();
    wr(1'b0, 6'h01);
    src_in = 6'h06;
    cyc(5);
    read(1'b1, v); check("R4", "disabled edges ignored", v, 6'h00);
    check("R4", "irq quiet", {5'b0, irq_req}, 6'h00);
    wr(1'b0, 6'h07);
    cyc(5);
    read(1'b1, v); check("R4", "level high not latched", v, 6'h00);
    src_in = 6'h00; cyc(4);
    src_in = 6'h02; cyc(4);
    read(1'b1, v); check("R4", "fresh edge latched", v, 6'h02);
  endtask

  task automatic t_sticky_clear();
    logic [5:0] v;
    do_reset();
    wr(1'b0, 6'h3f);
    src_in = 6'h21; cyc(4);
    src_in = 6'h00; cyc(4);
    read(1'b1, v); check("R5", "status held after source falls", v, 6'h21);
    src_in = 6'h21; cyc(4);
    read(1'b1, v); check("R5", "status held after re-edge", v, 6'h21);
    wr(1'b0, 6'h3e);
    read(1'b1, v); check("R5", "bit0 cleared by disable", v, 6'h20);
    check("R7", "irq held while bit5 set", {5'b0, irq_req}, 6'h01);
    cyc(2);
    check("R7", "irq still held", {5'b0, irq_req}, 6'h01);
    wr(1'b0, 6'h1e);
    read(1'b1, v); check("R5", "all cleared", v, 6'h00);
    check("R7", "irq same cycle as zero", {5'b0, irq_req}, 6'h01);
    cyc(1);
    check("R7", "irq low after zero", {5'b0, irq_req}, 6'h00);
    src_in = 6'h00;
  endtask

  task automatic t_coincident();
    logic [5:0] v;
    do_reset();
    wr(1'b0, 6'h08);
    src_in = 6'h08;
    cyc(2);
    bus_addr = 1'b0; bus_wr = 1'b1; bus_wdata = 6'h00;
    @(negedge clk);
    bus_wr = 1'b0;
    read(1'b1, v); check("R8", "edge with clear dropped", v, 6'h00);
    wr(1'b0, 6'h08);
    cyc(4);
    read(1'b1, v); check("R8", "dropped edge not recovered", v, 6'h00);
    check("R8", "irq stays low", {5'b0, irq_req}, 6'h00);
  endtask

  task automatic t_read_effect();
    logic [5:0] v;
    do_reset();
    wr(1'b0, 6'h3f);
    src_in = 6'h10; cyc(5);
    for (int k = 0; k < 6; k++) begin
      read(1'b1, v); @(negedge clk);
      read(1'b0, v); @(negedge clk);
    end
    read(1'b1, v); check("R9", "status after reads", v, 6'h10);
    check("R9", "irq after reads", {5'b0, irq_req}, 6'h01);
  endtask

  initial begin
    cyc(150000);
    bad++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_enable_rw();
    t_latency();
    t_disabled();
    t_sticky_clear();
    t_coincident();
    t_read_effect();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule